// File: doc/BRIEF.md
# USB IN Endpoint Controller

This block runs one IN endpoint of a USB function. Firmware fills a byte-wide packet buffer, then arms the endpoint by setting a packet-ready flag in the low control byte. The serial interface engine reports each IN token with a one-cycle pulse. The block answers each token with a response code. A data response streams the buffered bytes one per cycle. When the buffer is empty but the flag is set, the answer is an empty data packet. When the flag is clear, the answer is NAK, or an empty packet in isochronous mode. While the stall input is high, the answer is STALL. After a packet has been handed out, the hardware clears the ready flag and raises a pending interrupt cause.

The interrupt line merges three sticky causes: packet sent, buffer flushed, and stall raised. Firmware clears each cause by writing a 1 to its clear bit. The state machine has four named states:
- `ST_IDLE` waits for a token. On a token it moves to `ST_RESP`.
- `ST_RESP` presents the response code for one cycle. It moves to `ST_STREAM` for a data response, to `ST_DONE` for an armed empty packet, and otherwise back to `ST_IDLE`.
- `ST_STREAM` sends one byte per cycle. It moves to `ST_DONE` on the last byte.
- `ST_DONE` clears the flag, marks the packet as sent, and returns to `ST_IDLE`.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset, pkt_rdy, iso_mode, ep_level, irq_cause and irq are all 0.
- R2: With the buffer holding N>0 bytes and pkt_rdy set, a token gives one cycle with resp_valid and resp_code=0 (data). The N bytes then follow in load order, one per cycle on tx_valid, with tx_last on the Nth byte.
- R3: pkt_rdy stays 1 during the cycle after the last byte. It is 0 from the next cycle, and irq_cause bit 0 (packet sent) rises at that same edge.
- R4: With pkt_rdy set and the buffer empty, a token gets resp_code=3 (empty packet) and no bytes. pkt_rdy then clears and irq_cause bit 0 sets.
- R5: With pkt_rdy clear and iso_mode 0, a token gets resp_code=1 (NAK). pkt_rdy and irq_cause do not change.
- R6: Writing csr_hi_wdata bit 6 sets iso_mode. With iso_mode 1 and pkt_rdy clear, a token gets resp_code=3 and raises no interrupt cause. With pkt_rdy set, a token is answered as in R2.
- R7: While hw_stall is 1, a token gets resp_code=2 (STALL), and pkt_rdy and the buffer are kept. A rising edge of hw_stall sets irq_cause bit 2.
- R8: A flush write (csr_lo_wdata bit 3) in ST_IDLE with a non-empty buffer empties the buffer, clears pkt_rdy and sets irq_cause bit 1 at the next edge. The same write with an empty buffer changes nothing.
- R9: Buffer writes on fifo_wr while pkt_rdy is 1 are ignored.
- R10: Each irq_cause bit stays set until a 1 is written to the matching irq_clr bit. A set event in the same cycle wins over the clear. irq is the OR of the three cause bits.
- R11: Tokens that arrive while a response is in progress are ignored: each accepted token gives exactly one resp_valid cycle.
- R12: Writing csr_lo_wdata bit 0 as 1 sets pkt_rdy, unless a flush is acted on in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_wr | input | 1 | Load one byte into the packet buffer |
| fifo_wdata | input | DW | Byte to load |
| csr_lo_we | input | 1 | Write strobe for the low control byte |
| csr_lo_wdata | input | 8 | Low control byte: bit 0 sets packet-ready, bit 3 flushes |
| csr_hi_we | input | 1 | Write strobe for the high control byte |
| csr_hi_wdata | input | 8 | High control byte: bit 6 selects isochronous mode |
| irq_clr | input | 3 | Write-1-to-clear for the causes: bit 0 sent, bit 1 flush, bit 2 stall |
| hw_stall | input | 1 | Stall condition from the device logic |
| tok_in | input | 1 | IN token pulse from the serial interface engine |
| resp_valid | output | 1 | Response code is valid |
| resp_code | output | 2 | 0 data, 1 NAK, 2 STALL, 3 empty packet |
| tx_valid | output | 1 | Data byte is valid |
| tx_data | output | DW | Data byte |
| tx_last | output | 1 | Last byte of the packet |
| pkt_rdy | output | 1 | Packet-ready flag |
| iso_mode | output | 1 | Isochronous mode select |
| ep_level | output | log2(DEPTH)+1 | Bytes held in the buffer |
| irq_cause | output | 3 | Pending interrupt causes |
| irq | output | 1 | Endpoint interrupt |

## Verification
Two functions can meet in one cycle: the firmware clear of the packet-sent cause and the hardware completion that sets that cause. The bench holds irq_clr bit 0 high from the token edge through the exact edge at which the completion of a one-byte packet lands. It then expects the cause to remain set. A flush and a stall rising edge are also driven in the same cycle, and the bench expects both cause bits set, the buffer empty and the flag clear.

// File: rtl/usb_in_ep_pkg.sv
`timescale 1ns/1ps
package usb_in_ep_pkg;
    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_ZLP   = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESP,
        ST_STREAM,
        ST_DONE
    } ep_state_e;

    localparam int RDY_BIT   = 0;
    localparam int FLUSH_BIT = 3;
    localparam int ISO_BIT   = 6;

    localparam int CAUSE_SENT  = 0;
    localparam int CAUSE_FLUSH = 1;
    localparam int CAUSE_STALL = 2;
    localparam int N_CAUSE     = 3;
endpackage

// File: rtl/usb_in_ep_fifo.sv
`timescale 1ns/1ps
module usb_in_ep_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] rd_data,
    output logic [$clog2(DEPTH):0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && (level != LW'(DEPTH)) && !flush;
    assign pop_ok  = pop && (level != '0) && !flush;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/usb_in_ep_fsm.sv
`timescale 1ns/1ps
module usb_in_ep_fsm
    import usb_in_ep_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic          stall,
    input  logic          rdy,
    input  logic          iso,
    input  logic [LW-1:0] level,
    output logic          idle,
    output logic          resp_valid,
    output rsp_e          resp_code,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          pop,
    output logic          done
);
    ep_state_e state_q, state_d;
    rsp_e      rsp_q, rsp_d;
    logic      deliver_q;

    always_comb begin
        if (stall)    rsp_d = RSP_STALL;
        else if (rdy) rsp_d = (level == '0) ? RSP_ZLP : RSP_DATA;
        else          rsp_d = iso ? RSP_ZLP : RSP_NAK;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rsp_q     <= RSP_NAK;
            deliver_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && tok_in) begin
                rsp_q     <= rsp_d;
                deliver_q <= rdy && !stall;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tok_in) state_d = ST_RESP;
            ST_RESP: begin
                if (rsp_q == RSP_DATA) state_d = ST_STREAM;
                else if (deliver_q)    state_d = ST_DONE;
                else                   state_d = ST_IDLE;
            end
            ST_STREAM: if (level <= LW'(1)) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle       = 1'b0;
        resp_valid = 1'b0;
        tx_valid   = 1'b0;
        tx_last    = 1'b0;
        done       = 1'b0;
        resp_code  = rsp_q;
        unique case (state_q)
            ST_IDLE:   idle = 1'b1;
            ST_RESP:   resp_valid = 1'b1;
            ST_STREAM: begin
                tx_valid = 1'b1;
                tx_last  = (level == LW'(1));
            end
            ST_DONE:   done = 1'b1;
            default:   idle = 1'b0;
        endcase
        pop = tx_valid;
    end
endmodule

// File: rtl/usb_in_ep_irq.sv
`timescale 1ns/1ps
module usb_in_ep_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] cause,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (!rst_n)         cause[i] <= 1'b0;
            else if (set_ev[i]) cause[i] <= 1'b1;
            else if (clr[i])    cause[i] <= 1'b0;
        end
    end

    assign irq = |cause;
endmodule

// File: rtl/usb_in_ep_ctrl.sv
`timescale 1ns/1ps
module usb_in_ep_ctrl
    import usb_in_ep_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fifo_wr,
    input  logic [DW-1:0]          fifo_wdata,
    input  logic                   csr_lo_we,
    input  logic [7:0]             csr_lo_wdata,
    input  logic                   csr_hi_we,
    input  logic [7:0]             csr_hi_wdata,
    input  logic [2:0]             irq_clr,
    input  logic                   hw_stall,
    input  logic                   tok_in,
    output logic                   resp_valid,
    output logic [1:0]             resp_code,
    output logic                   tx_valid,
    output logic [DW-1:0]          tx_data,
    output logic                   tx_last,
    output logic                   pkt_rdy,
    output logic                   iso_mode,
    output logic [$clog2(DEPTH):0] ep_level,
    output logic [2:0]             irq_cause,
    output logic                   irq
);
    localparam int LW = $clog2(DEPTH) + 1;

    logic   idle, pop, done, push;
    logic   flush_act, rdy_set, stall_q;
    rsp_e   code;
    logic [N_CAUSE-1:0] set_ev;
    logic   unused_bits;

    assign unused_bits = ^{csr_lo_wdata[7:4], csr_lo_wdata[2:1],
                           csr_hi_wdata[7], csr_hi_wdata[5:0]};

    assign flush_act = csr_lo_we && csr_lo_wdata[FLUSH_BIT] && idle && (ep_level != '0);
    assign rdy_set   = csr_lo_we && csr_lo_wdata[RDY_BIT] && !flush_act;
    assign push      = fifo_wr && !pkt_rdy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_rdy  <= 1'b0;
            iso_mode <= 1'b0;
            stall_q  <= 1'b0;
        end else begin
            stall_q <= hw_stall;
            if (done || flush_act) pkt_rdy <= 1'b0;
            else if (rdy_set)      pkt_rdy <= 1'b1;
            if (csr_hi_we)         iso_mode <= csr_hi_wdata[ISO_BIT];
        end
    end

    usb_in_ep_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (fifo_wdata),
        .pop       (pop),
        .flush     (flush_act),
        .rd_data   (tx_data),
        .level     (ep_level)
    );

    usb_in_ep_fsm #(.LW(LW)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_in     (tok_in),
        .stall      (hw_stall),
        .rdy        (pkt_rdy),
        .iso        (iso_mode),
        .level      (ep_level),
        .idle       (idle),
        .resp_valid (resp_valid),
        .resp_code  (code),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .pop        (pop),
        .done       (done)
    );

    assign resp_code = code;

    always_comb begin
        set_ev              = '0;
        set_ev[CAUSE_SENT]  = done;
        set_ev[CAUSE_FLUSH] = flush_act;
        set_ev[CAUSE_STALL] = hw_stall && !stall_q;
    end

    usb_in_ep_irq #(.N(N_CAUSE)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_ev),
        .clr    (irq_clr),
        .cause  (irq_cause),
        .irq    (irq)
    );
endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
`timescale 1ns/1ps
module usb_in_ep_ctrl_chk #(
    parameter int LW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hw_stall,
    input logic          csr_lo_we,
    input logic [7:0]    csr_lo_wdata,
    input logic [2:0]    irq_clr,
    input logic          resp_valid,
    input logic [1:0]    resp_code,
    input logic          tx_valid,
    input logic          pkt_rdy,
    input logic [LW-1:0] ep_level,
    input logic [2:0]    irq_cause
);
    AST_NO_RESP_DATA_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && tx_valid)); // R2

    AST_SENT_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_cause[0]) |-> !pkt_rdy); // R3

    AST_STALL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(hw_stall)) |-> resp_code == 2'd2); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_cause[1]) |-> (ep_level == '0 && !pkt_rdy)); // R8

    AST_LOCKED_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_rdy && !tx_valid && !(csr_lo_we && csr_lo_wdata[3]))
        |=> ep_level == $past(ep_level)); // R9

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_cause & $past(irq_cause & ~irq_clr)) == $past(irq_cause & ~irq_clr))); // R10

    AST_SINGLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R11
endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk #(.LW($clog2(DEPTH) + 1)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_stall     (hw_stall),
    .csr_lo_we    (csr_lo_we),
    .csr_lo_wdata (csr_lo_wdata),
    .irq_clr      (irq_clr),
    .resp_valid   (resp_valid),
    .resp_code    (resp_code),
    .tx_valid     (tx_valid),
    .pkt_rdy      (pkt_rdy),
    .ep_level     (ep_level),
    .irq_cause    (irq_cause)
);

// File: tb/usb_in_ep_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_in_ep_ctrl_tb_top;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_wr = 1'b0;
    logic [DW-1:0] fifo_wdata = '0;
    logic          csr_lo_we = 1'b0;
    logic [7:0]    csr_lo_wdata = '0;
    logic          csr_hi_we = 1'b0;
    logic [7:0]    csr_hi_wdata = '0;
    logic [2:0]    irq_clr = '0;
    logic          hw_stall = 1'b0;
    logic          tok_in = 1'b0;
    logic          resp_valid, tx_valid, tx_last, pkt_rdy, iso_mode, irq;
    logic [1:0]    resp_code;
    logic [DW-1:0] tx_data;
    logic [LW-1:0] ep_level;
    logic [2:0]    irq_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model of the endpoint, built from the requirements
    logic [DW-1:0] model_q[$];
    bit model_rdy = 0, model_iso = 0, model_stall = 0;

    // scoreboard queues
    logic [1:0]    exp_resp[$];
    string         exp_rtag[$];
    logic [DW:0]   exp_byte[$];

    always #4 clk = ~clk; // 125 MHz

    usb_in_ep_ctrl #(.DW(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .csr_lo_we(csr_lo_we), .csr_lo_wdata(csr_lo_wdata),
        .csr_hi_we(csr_hi_we), .csr_hi_wdata(csr_hi_wdata),
        .irq_clr(irq_clr), .hw_stall(hw_stall), .tok_in(tok_in),
        .resp_valid(resp_valid), .resp_code(resp_code), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .pkt_rdy(pkt_rdy),
        .iso_mode(iso_mode), .ep_level(ep_level), .irq_cause(irq_cause), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expectations as the design produces results
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (resp_valid) begin
                if (exp_resp.size() == 0) begin
                    check(1'b0, "R11 unexpected response", int'(resp_code), 0);
                end else begin
                    automatic logic [1:0] e = exp_resp.pop_front();
                    automatic string t = exp_rtag.pop_front();
                    check(resp_code == e, t, int'(resp_code), int'(e));
                end
            end
            if (tx_valid) begin
                if (exp_byte.size() == 0) begin
                    check(1'b0, "R2 unexpected byte", int'(tx_data), 0);
                end else begin
                    automatic logic [DW:0] eb = exp_byte.pop_front();
                    check({tx_last, tx_data} == eb, "R2 streamed byte/last",
                          int'({tx_last, tx_data}), int'(eb));
                end
            end
        end
    end

    task automatic load(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fifo_wr    = 1'b1;
            fifo_wdata = base + DW'(i);
            if (!model_rdy && model_q.size() < DEPTH) model_q.push_back(base + DW'(i));
        end
        @(negedge clk);
        fifo_wr = 1'b0;
    endtask

    task automatic write_lo(input logic [7:0] v);
        @(negedge clk);
        csr_lo_we    = 1'b1;
        csr_lo_wdata = v;
        @(negedge clk);
        csr_lo_we    = 1'b0;
        csr_lo_wdata = '0;
    endtask

    task automatic write_hi(input logic [7:0] v);
        @(negedge clk);
        csr_hi_we    = 1'b1;
        csr_hi_wdata = v;
        model_iso    = v[6];
        @(negedge clk);
        csr_hi_we    = 1'b0;
    endtask

    task automatic clear_irq(input logic [2:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = '0;
    endtask

    // driver: computes the expected answer and pushes it into the scoreboard
    task automatic expect_token(input string tag);
        logic [1:0] r;
        if (model_stall)    r = 2'd2;
        else if (model_rdy) r = (model_q.size() == 0) ? 2'd3 : 2'd0;
        else                r = model_iso ? 2'd3 : 2'd1;
        exp_resp.push_back(r);
        exp_rtag.push_back(tag);
        if (r == 2'd0) begin
            for (int i = 0; i < model_q.size(); i++)
                exp_byte.push_back({(i == model_q.size() - 1), model_q[i]});
        end
        if (!model_stall && model_rdy) begin
            model_q.delete();
            model_rdy = 0;
        end
    endtask

    task automatic send_token(input string tag, input bit settle);
        expect_token(tag);
        @(negedge clk);
        tok_in = 1'b1;
        @(negedge clk);
        tok_in = 1'b0;
        if (settle) repeat (DEPTH + 6) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({pkt_rdy, iso_mode, irq_cause, irq} == '0, "R1 flags after reset",
              int'({pkt_rdy, iso_mode, irq_cause, irq}), 0);
        check(ep_level == '0, "R1 level after reset", int'(ep_level), 0);

        // R2/R3/R12/R9 four-byte packet with exact timing
        load(4, 8'hA0);
        check(ep_level == LW'(4), "R2 level after load", int'(ep_level), 4);
        write_lo(8'h01);
        model_rdy = 1;
        check(pkt_rdy == 1'b1, "R12 ready set by bit 0", int'(pkt_rdy), 1);
        load(2, 8'h55);
        check(ep_level == LW'(4), "R9 write ignored while ready", int'(ep_level), 4);
        send_token("R2 data response", 1'b0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(pkt_rdy == 1'b1 && irq_cause[0] == 1'b0, "R3 still ready in done cycle",
              int'({pkt_rdy, irq_cause[0]}), 2);
        @(negedge clk);
        check(pkt_rdy == 1'b0 && irq_cause[0] == 1'b1, "R3 ready cleared, sent cause",
              int'({pkt_rdy, irq_cause[0]}), 1);
        check(irq == 1'b1, "R10 irq is OR of causes", int'(irq), 1);
        repeat (4) @(negedge clk);
        check(irq_cause[0] == 1'b1, "R10 cause sticky", int'(irq_cause[0]), 1);
        clear_irq(3'b001);
        check(irq_cause == 3'b000 && irq == 1'b0, "R10 write-1 clear", int'(irq_cause), 0);

        // R4 armed empty packet
        write_lo(8'h01);
        model_rdy = 1;
        send_token("R4 empty packet response", 1'b1);
        check(pkt_rdy == 1'b0 && irq_cause[0] == 1'b1, "R4 ready cleared, sent cause",
              int'({pkt_rdy, irq_cause[0]}), 1);
        clear_irq(3'b001);

        // R5 NAK when not ready
        send_token("R5 NAK response", 1'b1);
        check(pkt_rdy == 1'b0 && irq_cause == 3'b000, "R5 no side effects",
              int'({pkt_rdy, irq_cause}), 0);

        // R6 isochronous mode
        write_hi(8'h40);
        check(iso_mode == 1'b1, "R6 iso select bit 6", int'(iso_mode), 1);
        send_token("R6 iso unarmed empty packet", 1'b1);
        check(irq_cause == 3'b000, "R6 no cause when unarmed", int'(irq_cause), 0);
        load(2, 8'h30);
        write_lo(8'h01);
        model_rdy = 1;
        send_token("R6 iso data response", 1'b1);
        check(irq_cause[0] == 1'b1 && pkt_rdy == 1'b0, "R6 iso packet sent",
              int'({irq_cause[0], pkt_rdy}), 2);
        clear_irq(3'b001);
        write_hi(8'h00);

        // R7 stall
        load(3, 8'h70);
        write_lo(8'h01);
        model_rdy = 1;
        @(negedge clk);
        hw_stall = 1'b1;
        model_stall = 1;
        @(negedge clk);
        check(irq_cause[2] == 1'b1, "R7 stall rise sets cause", int'(irq_cause), 4);
        send_token("R7 stall response", 1'b1);
        check(pkt_rdy == 1'b1 && ep_level == LW'(3), "R7 packet kept under stall",
              int'({pkt_rdy, ep_level}), 32'h23);

        // R8 flush together with a stall rising edge
        @(negedge clk);
        hw_stall = 1'b0;
        model_stall = 0;
        clear_irq(3'b100);
        @(negedge clk);
        hw_stall     = 1'b1;
        csr_lo_we    = 1'b1;
        csr_lo_wdata = 8'h08;
        @(negedge clk);
        csr_lo_we    = 1'b0;
        csr_lo_wdata = '0;
        model_q.delete();
        model_rdy = 0;
        check(irq_cause == 3'b110, "R8 flush and stall causes together", int'(irq_cause), 6);
        check(ep_level == '0 && pkt_rdy == 1'b0, "R8 flush empties and clears",
              int'({pkt_rdy, ep_level}), 0);
        hw_stall = 1'b0;
        clear_irq(3'b110);

        // R8 flush on an empty buffer does nothing
        write_lo(8'h01);
        model_rdy = 1;
        write_lo(8'h08);
        check(pkt_rdy == 1'b1 && irq_cause[1] == 1'b0, "R8 empty flush ignored",
              int'({pkt_rdy, irq_cause[1]}), 2);
        send_token("R4 empty packet after empty flush", 1'b1);
        clear_irq(3'b001);

        // R10 clear and completion in the same cycle
        load(1, 8'hC5);
        write_lo(8'h01);
        model_rdy = 1;
        expect_token("R2 one-byte packet");
        @(negedge clk);
        tok_in  = 1'b1;
        irq_clr = 3'b001;
        @(posedge clk);
        @(negedge clk);
        tok_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        irq_clr = 3'b000;
        check(irq_cause[0] == 1'b1, "R10 set wins over clear", int'(irq_cause[0]), 1);
        clear_irq(3'b001);

        // R11 token held during streaming
        load(3, 8'hE0);
        write_lo(8'h01);
        model_rdy = 1;
        expect_token("R11 single response for held token");
        @(negedge clk);
        tok_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        tok_in = 1'b0;
        repeat (DEPTH + 6) @(posedge clk);
        @(negedge clk);
        check(exp_resp.size() == 0, "R11 all responses seen", exp_resp.size(), 0);
        check(exp_byte.size() == 0, "R2 all bytes seen", exp_byte.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule